// File: doc/BRIEF.md
# Dual 32-bit Interval Timer with Compare Matching

This block is a bus-attached timer with two independent 32-bit up-counters, the low half and the high half. Each half has its own period register and a two-bit run mode: stopped, single-shot or repeating. Each raises its own one-cycle interrupt when its count reaches its period. A repeating half returns to zero. A single-shot half stops where it is and clears its own run mode.

The low half also feeds a bank of eight compare registers. Whenever the running low count equals any of them, a shared compare interrupt pulses for one cycle and the count carries on. With the low half set to repeat over the full 32-bit range, it works as a free-running time base. Software then schedules events by writing compare values ahead of the count.

A global control register picks the timer mode and releases each half from reset. Only the dual independent 32-bit mode counts. Software reads and writes every register through a simple single-cycle register bus, and read data comes back registered.

Top module: `dual_timer_cmp`

## Requirements
- R1: After the synchronous reset, these registers read 0: counters, periods, run-control, global control and compare registers. The identification word at offset 0x00 reads the PERIPH_ID parameter, and all three interrupts are low.
- R2: With run mode 2 (repeat) and period P, the low half's interrupt is a one-cycle pulse. It recurs every P+1 cycles, because the count runs 0..P and then returns to 0.
- R3: With run mode 1 (single-shot), the half pulses its interrupt once when the count equals the period. The count then stays at the period and the run-mode field reads back 0.
- R4: A counter holds its value in any of these cases: its reset bit (global control bit 0 for low, bit 1 for high) is 0, its run mode is 0, or the timer-mode field (global control bits 3:2) is not 1.
- R5: A write to a counter register (low 0x10, high 0x14) loads that value. A running counter steps up by one per cycle and wraps from 0xFFFFFFFF to 0.
- R6: The compare interrupt pulses one cycle after a cycle in which the low half is running and its count equals at least one compare register. Several equal registers give one pulse, not several. No pulse occurs while the low half is held.
- R7: Register layout is as follows. Low and high periods are at 0x18 and 0x1C. Run-control is at 0x20, with the low run mode in bits 7:6 and the high run mode in bits 23:22. Global control is at 0x24. Compare register k is at 0x60+4k for k = 0..7. All of these read back what was written.
- R8: The high half runs independently with its own period and interrupt. In repeat mode its pulses recur every P_hi+1 cycles, whatever the low half's period is.
- R9: A read presents its data on the bus the cycle after the read strobe. The read data holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each counter step is one cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq_lo | output | 1 | Low-half period interrupt pulse |
| irq_hi | output | 1 | High-half period interrupt pulse |
| irq_cmp | output | 1 | Compare-match interrupt pulse |

## Verification
The repeating mode is tried with several random periods. Measuring the spacing between pulses separates a correct P+1 cycle from an off-by-one return to zero. The compare bank is loaded with random values, some inside and some beyond the period. Counting compare pulses over exactly one period then shows whether out-of-range values are ignored and whether duplicate values merge into one pulse. Directed cases start the counter just below 0xFFFFFFFF to expose wrap handling. They also hold one half in reset, stopped or in the wrong timer mode, and reading back the counter shows whether it stayed still. The single-shot case shows whether the count stops at the period and whether the run mode clears itself.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  typedef enum logic [1:0] {
    RUN_OFF    = 2'd0,
    RUN_ONCE   = 2'd1,
    RUN_REPEAT = 2'd2,
    RUN_RSVD   = 2'd3
  } run_mode_e;

  localparam logic [1:0] TMODE_DUAL32 = 2'd1;

  localparam int ADR_ID       = 'h00;
  localparam int ADR_CNT_BASE = 'h10;
  localparam int ADR_PRD_BASE = 'h18;
  localparam int ADR_RUNCTL   = 'h20;
  localparam int ADR_GCTL     = 'h24;
  localparam int ADR_CMP_BASE = 'h60;

  localparam int N_HALVES = 2;

  function automatic int run_pos(input int half);
    return (half == 0) ? 6 : 22;
  endfunction

endpackage

// File: rtl/dtmr_half.sv
module dtmr_half
  import dtmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_ok,
  input  logic [1:0]   mode,
  input  logic         cnt_we,
  input  logic         prd_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] prd,
  output logic         active,
  output logic         once_done,
  output logic         irq
);

  logic at_end;
  logic step;

  assign active    = run_ok && (mode == RUN_ONCE || mode == RUN_REPEAT);
  assign step      = active && !cnt_we;
  assign at_end    = (cnt == prd);
  assign once_done = step && at_end && (mode == RUN_ONCE);

  always_ff @(posedge clk) begin
    if (rst) begin
      prd <= '0;
    end else if (prd_we) begin
      prd <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt_we) begin
      cnt <= wdata;
    end else if (step) begin
      if (at_end) begin
        if (mode == RUN_REPEAT) cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= step && at_end;
  end

endmodule

// File: rtl/dtmr_cmp_bank.sv
module dtmr_cmp_bank #(
  parameter int W     = 32,
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     cnt,
  input  logic             enable,
  output logic [W-1:0]     rd_val,
  output logic             irq
);

  logic [W-1:0] cmp_q [N];
  logic [N-1:0] match;

  for (genvar k = 0; k < N; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[k] <= '0;
      end else if (we && idx == IDX_W'(k)) begin
        cmp_q[k] <= wdata;
      end
    end
    assign match[k] = (cmp_q[k] == cnt);
  end

  assign rd_val = cmp_q[idx];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= enable && (|match);
  end

endmodule

// File: rtl/dual_timer_cmp.sv
module dual_timer_cmp
  import dtmr_pkg::*;
#(
  parameter int             DW        = 32,
  parameter int             AW        = 8,
  parameter int             N_CMP     = 8,
  parameter logic [DW-1:0]  PERIPH_ID = 32'h0107_0A31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_lo,
  output logic          irq_hi,
  output logic          irq_cmp
);

  localparam int IDX_W   = (N_CMP > 1) ? $clog2(N_CMP) : 1;
  localparam int CMP_END = ADR_CMP_BASE + 4 * N_CMP;

  logic wr_stb, rd_stb;
  assign wr_stb = bus_sel && bus_wr;
  assign rd_stb = bus_sel && !bus_wr;

  // global control
  logic [1:0] tmode;
  logic [1:0] half_rs;
  always_ff @(posedge clk) begin
    if (rst) begin
      tmode   <= '0;
      half_rs <= '0;
    end else if (wr_stb && bus_addr == AW'(ADR_GCTL)) begin
      tmode   <= bus_wdata[3:2];
      half_rs <= bus_wdata[1:0];
    end
  end

  logic runctl_we;
  assign runctl_we = wr_stb && bus_addr == AW'(ADR_RUNCTL);

  logic [1:0]    run_mode [N_HALVES];
  logic [DW-1:0] cnt_q    [N_HALVES];
  logic [DW-1:0] prd_q    [N_HALVES];
  logic [N_HALVES-1:0] cnt_we, prd_we, active, once_done, irq_v;

  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    localparam int POS = run_pos(h);

    assign cnt_we[h] = wr_stb && bus_addr == AW'(ADR_CNT_BASE + 4 * h);
    assign prd_we[h] = wr_stb && bus_addr == AW'(ADR_PRD_BASE + 4 * h);

    always_ff @(posedge clk) begin
      if (rst) begin
        run_mode[h] <= RUN_OFF;
      end else if (runctl_we) begin
        run_mode[h] <= bus_wdata[POS +: 2];
      end else if (once_done[h]) begin
        run_mode[h] <= RUN_OFF;
      end
    end

    dtmr_half #(.W(DW)) u_half (
      .clk       (clk),
      .rst       (rst),
      .run_ok    (half_rs[h] && tmode == TMODE_DUAL32),
      .mode      (run_mode[h]),
      .cnt_we    (cnt_we[h]),
      .prd_we    (prd_we[h]),
      .wdata     (bus_wdata),
      .cnt       (cnt_q[h]),
      .prd       (prd_q[h]),
      .active    (active[h]),
      .once_done (once_done[h]),
      .irq       (irq_v[h])
    );
  end

  assign irq_lo = irq_v[0];
  assign irq_hi = irq_v[1];

  // compare bank on the low half
  logic             in_cmp;
  logic [IDX_W-1:0] cmp_idx;
  logic [DW-1:0]    cmp_rd;
  logic [AW-1:0]    cmp_off;

  assign in_cmp  = (bus_addr >= AW'(ADR_CMP_BASE)) && (int'(bus_addr) < CMP_END);
  assign cmp_off = bus_addr - AW'(ADR_CMP_BASE);
  assign cmp_idx = cmp_off[IDX_W+1:2];

  dtmr_cmp_bank #(.W(DW), .N(N_CMP), .IDX_W(IDX_W)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_stb && in_cmp),
    .idx    (cmp_idx),
    .wdata  (bus_wdata),
    .cnt    (cnt_q[0]),
    .enable (active[0] && !cnt_we[0]),
    .rd_val (cmp_rd),
    .irq    (irq_cmp)
  );

  // read path
  logic [DW-1:0] runctl_rd;
  always_comb begin
    runctl_rd = '0;
    runctl_rd[run_pos(0) +: 2] = run_mode[0];
    runctl_rd[run_pos(1) +: 2] = run_mode[1];
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (in_cmp) begin
      rd_mux = cmp_rd;
    end else begin
      case (bus_addr)
        AW'(ADR_ID):           rd_mux = PERIPH_ID;
        AW'(ADR_CNT_BASE):     rd_mux = cnt_q[0];
        AW'(ADR_CNT_BASE + 4): rd_mux = cnt_q[1];
        AW'(ADR_PRD_BASE):     rd_mux = prd_q[0];
        AW'(ADR_PRD_BASE + 4): rd_mux = prd_q[1];
        AW'(ADR_RUNCTL):       rd_mux = runctl_rd;
        AW'(ADR_GCTL):         rd_mux = DW'({tmode, half_rs});
        default:               rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_stb) bus_rdata <= rd_mux;
  end

  // flat views for the checker
  logic [DW-1:0] lo_cnt, lo_prd, hi_cnt, hi_prd;
  logic [1:0]    lo_mode;
  assign lo_cnt  = cnt_q[0];
  assign lo_prd  = prd_q[0];
  assign hi_cnt  = cnt_q[1];
  assign hi_prd  = prd_q[1];
  assign lo_mode = run_mode[0];

endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_lo,
  input logic          irq_hi,
  input logic          irq_cmp,
  input logic [DW-1:0] lo_cnt,
  input logic [DW-1:0] lo_prd,
  input logic [DW-1:0] hi_cnt,
  input logic [DW-1:0] hi_prd,
  input logic [1:0]    lo_mode,
  input logic [1:0]    tmode,
  input logic [1:0]    active,
  input logic [1:0]    cnt_we,
  input logic          runctl_we
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_lo && !irq_hi && !irq_cmp));

  a_r2_lo_irq_on_match: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> $past(active[0] && !cnt_we[0] && lo_cnt == lo_prd));

  a_r8_hi_irq_on_match: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> $past(active[1] && !cnt_we[1] && hi_cnt == hi_prd));

  a_r3_once_clears: assert property (@(posedge clk) disable iff (rst)
    (active[0] && !cnt_we[0] && !runctl_we && lo_mode == 2'd1 && lo_cnt == lo_prd)
      |=> (lo_mode == 2'd0));

  a_r4_lo_hold: assert property (@(posedge clk) disable iff (rst)
    (!active[0] && !cnt_we[0]) |=> $stable(lo_cnt));

  a_r4_mode_gate: assert property (@(posedge clk) disable iff (rst)
    (tmode != 2'd1) |-> (active == 2'b00));

  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (active[0] && !cnt_we[0] && lo_cnt != lo_prd) |=> (lo_cnt == $past(lo_cnt) + 1'b1));

  a_r6_cmp_needs_run: assert property (@(posedge clk) disable iff (rst)
    irq_cmp |-> $past(active[0]));

endmodule

bind dual_timer_cmp dtmr_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_lo    (irq_lo),
  .irq_hi    (irq_hi),
  .irq_cmp   (irq_cmp),
  .lo_cnt    (lo_cnt),
  .lo_prd    (lo_prd),
  .hi_cnt    (hi_cnt),
  .hi_prd    (hi_prd),
  .lo_mode   (lo_mode),
  .tmode     (tmode),
  .active    (active),
  .cnt_we    (cnt_we),
  .runctl_we (runctl_we)
);

// File: tb/sim_dual_timer_cmp.sv
module sim_dual_timer_cmp;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi, irq_cmp;

  always #4 clk = ~clk;

  dual_timer_cmp u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_cmp(irq_cmp)
  );

  localparam logic [7:0] A_ID = 8'h00, A_CLO = 8'h10, A_CHI = 8'h14,
                         A_PLO = 8'h18, A_PHI = 8'h1C, A_RUN = 8'h20,
                         A_GCT = 8'h24, A_CMP = 8'h60;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  function automatic logic pick(input int which);
    return (which == 0) ? irq_lo : (which == 1) ? irq_hi : irq_cmp;
  endfunction

  // negedges until the chosen interrupt is seen high, or -1
  task automatic wait_pulse(input int which, input int limit, output int waited);
    waited = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (pick(which)) begin waited = i; break; end
    end
  endtask

  task automatic count_pulses(input int which, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pick(which)) cnt++;
    end
  endtask

  task automatic stop_all();
    wr(A_GCT, 32'h0);
    wr(A_RUN, 32'h0);
  endtask

  function automatic int exp_cmp_hits(input int p, input int v[8]);
    int c = 0;
    for (int i = 0; i < 8; i++) begin
      bit dup = 0;
      for (int j = 0; j < i; j++) if (v[j] == v[i]) dup = 1;
      if (!dup && v[i] <= p) c++;
    end
    return c;
  endfunction

  initial begin
    int unsigned seed0;
    logic [31:0] d;
    int w, c, p, ph;
    int v[8];

    seed0 = $urandom(32'd4242);
    repeat (5) @(negedge clk);
    rst = 0;

    // R1: reset state
    chk("R1 irq_lo", {31'b0, irq_lo}, 32'h0);
    chk("R1 irq_cmp", {31'b0, irq_cmp}, 32'h0);
    rd(A_ID, d);  chk("R1 id", d, 32'h0107_0A31);
    rd(A_CLO, d); chk("R1 cnt_lo", d, 0);
    rd(A_PHI, d); chk("R1 prd_hi", d, 0);
    rd(A_RUN, d); chk("R1 runctl", d, 0);
    rd(A_GCT, d); chk("R1 gctl", d, 0);
    rd(A_CMP + 8'h1C, d); chk("R1 cmp7", d, 0);

    // R7: register layout readback
    wr(A_PLO, 32'hCAFE_0001);
    wr(A_PHI, 32'h0BAD_F00D);
    wr(A_CMP + 8'h14, 32'h1234_5678);
    wr(A_RUN, 32'h0080_0040);
    rd(A_PLO, d); chk("R7 prd_lo", d, 32'hCAFE_0001);
    rd(A_PHI, d); chk("R7 prd_hi", d, 32'h0BAD_F00D);
    rd(A_CMP + 8'h14, d); chk("R7 cmp5", d, 32'h1234_5678);
    rd(A_RUN, d); chk("R7 runctl fields", d, 32'h0080_0040);
    // R9: read data holds until next read
    wr(A_PLO, 32'h0);
    chk("R9 rdata hold", bus_rdata, 32'h0080_0040);
    rd(A_CMP + 8'h14, d); chk("R9 rdata next read", d, 32'h1234_5678);
    for (int k = 0; k < 8; k++) wr(A_CMP + 8'(4 * k), 32'h8000_0000);
    stop_all();

    // R4: held while reset bit low, while stopped, while timer mode != 1
    wr(A_CLO, 32'd5);
    wr(A_PLO, 32'd100);
    wr(A_RUN, 32'h0000_0080);
    wr(A_GCT, 32'h0000_0006);          // mode 1, low half in reset
    repeat (10) @(negedge clk);
    rd(A_CLO, d); chk("R4 hold reset bit", d, 32'd5);
    wr(A_GCT, 32'h0000_0003);          // mode 0, both released
    repeat (10) @(negedge clk);
    rd(A_CLO, d); chk("R4 hold tmode", d, 32'd5);
    wr(A_RUN, 32'h0);
    wr(A_GCT, 32'h0000_0007);          // runs allowed, but stopped
    repeat (10) @(negedge clk);
    rd(A_CLO, d); chk("R4 hold stopped", d, 32'd5);
    // R6: held low half gives no compare pulse even on an equal value
    wr(A_CMP, 32'd5);
    count_pulses(2, 20, c); chk("R6 no cmp when held", c, 0);
    stop_all();

    // R2: repeating mode with random periods
    for (int r = 0; r < 4; r++) begin
      p = 3 + int'($urandom % 40);
      wr(A_PLO, p);
      wr(A_CLO, 0);
      wr(A_RUN, 32'h0000_0080);
      wr(A_GCT, 32'h0000_0005);
      wait_pulse(0, 3 * p + 20, w);
      chk("R2 first pulse seen", {31'b0, w > 0}, 1);
      wait_pulse(0, 3 * p + 20, w);
      chk("R2 pulse spacing", w, p + 1);
      @(negedge clk);
      chk("R2 pulse width", {31'b0, irq_lo}, 0);
      stop_all();
    end

    // R8: high half independent of the low half
    p = 11; ph = 6;
    wr(A_PLO, p); wr(A_CLO, 0);
    wr(A_PHI, ph); wr(A_CHI, 0);
    wr(A_RUN, 32'h0080_0080);
    wr(A_GCT, 32'h0000_0007);
    wait_pulse(1, 40, w);
    wait_pulse(1, 40, w);
    chk("R8 hi spacing", w, ph + 1);
    wait_pulse(0, 40, w);
    wait_pulse(0, 40, w);
    chk("R8 lo spacing alongside", w, p + 1);
    stop_all();

    // R3: single-shot
    p = 9;
    wr(A_PLO, p); wr(A_CLO, 0);
    wr(A_RUN, 32'h0000_0040);
    wr(A_GCT, 32'h0000_0005);
    wait_pulse(0, 40, w);
    chk("R3 one pulse seen", {31'b0, w > 0}, 1);
    count_pulses(0, 40, c); chk("R3 no further pulse", c, 0);
    rd(A_CLO, d); chk("R3 count parked at period", d, p);
    rd(A_RUN, d); chk("R3 run mode cleared", d, 0);
    stop_all();

    // R6: random compare values over one full period
    for (int r = 0; r < 5; r++) begin
      p = 8 + int'($urandom % 33);
      for (int k = 0; k < 8; k++)
        v[k] = (r == 4) ? 3 : int'($urandom % (2 * p + 1));
      for (int k = 0; k < 8; k++) wr(A_CMP + 8'(4 * k), v[k]);
      wr(A_PLO, p); wr(A_CLO, 0);
      wr(A_RUN, 32'h0000_0080);
      wr(A_GCT, 32'h0000_0005);
      wait_pulse(0, 3 * p + 20, w);
      count_pulses(2, p + 1, c);
      chk("R6 compare pulses per period", c, exp_cmp_hits(p, v));
      stop_all();
    end

    // R5: wrap through 0xFFFFFFFF, compare keeps firing after wrap
    for (int k = 0; k < 8; k++) wr(A_CMP + 8'(4 * k), 32'h8000_0000);
    wr(A_CMP, 32'd1);
    wr(A_PLO, 32'hFFFF_FFFF);
    wr(A_CLO, 32'hFFFF_FFFD);
    wr(A_RUN, 32'h0000_0080);
    wr(A_GCT, 32'h0000_0005);
    wait_pulse(0, 10, w);
    chk("R5 wrap pulse", {31'b0, w > 0}, 1);
    wait_pulse(2, 10, w);
    chk("R5 count after wrap hits compare 1", w, 2);
    stop_all();
    rd(A_CLO, d);
    chk("R5 small count after wrap", {31'b0, d < 32'd20}, 1);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule